// File: doc/BRIEF.md
# Outbound Host-to-PCI Address Window Translator

This block sits between a host-side address source and the outbound PCI path. It compares each host address against a small set of programmable windows. The default has three: two memory windows and one I/O window. When a window claims the address, the block passes on a translated PCI address and a routing flag. The flag says whether the access goes to the primary PCI bus or to the CardBus side.

Each window has three 32-bit registers: a size mask, a base and a remap/control word. The base and remap target keep only 32 KiB-aligned address bits. The remap word carries the window enable and the CardBus routing bit. With only one I/O window, the choice between PCI and CardBus for I/O comes down to flipping that window's routing bit. Software programs the windows through a simple write port and reads them back through a combinational read port. Each lookup is presented with a valid strobe, and its result appears in the next cycle.

Top module: `owt_xlate`

## Requirements
- R1: After reset every window register reads zero and every lookup returns a miss.
- R2: A base register keeps only address bits 31:15; bits 14:0 always read back as zero.
- R3: A remap register keeps bit 0 (window enable), bit 2 (CardBus routing) and bits 31:15 (translation target); all other bits read back as zero. The size mask register keeps all 32 bits.
- R4: Window w (0 = memory 1, 1 = memory 2, 2 = I/O) has its mask, base and remap registers at byte offsets 0x120 + 12·w, 0x124 + 12·w and 0x128 + 12·w.
- R5: A window matches when (address AND mask) equals (base AND mask).
- R6: A window whose enable bit is clear never produces a hit.
- R7: When several enabled windows match, the result reports the lowest-numbered one.
- R8: The translated address takes the target bits under the mask and the host address bits outside it: (target AND mask) OR (address AND NOT mask).
- R9: The CardBus flag of a hit equals bit 2 of the winning window's remap register, so clearing or setting that bit moves the I/O window between the PCI bus and CardBus.
- R10: The result is valid exactly one cycle after a lookup strobe. When the result is a miss, or no lookup was made, the window index, address and CardBus flag are zero.
- R11: Writes to offsets outside the nine window registers, including misaligned ones, change nothing, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Byte offset of the register being written |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_addr | input | 12 | Byte offset of the register being read |
| cfg_rdata | output | 32 | Read data, combinational from cfg_rd_addr |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Host address to translate |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | Some enabled window matched |
| res_win | output | 2 | Index of the winning window |
| res_addr | output | 32 | Translated PCI address |
| res_cb | output | 1 | Winning window routes to CardBus |

## Verification
A register write takes effect at the clock edge where its strobe is sampled. The read port is combinational, so the bench drives a read offset after a falling edge and samples the data shortly after. A lookup driven after a falling edge is captured at the next rising edge, and its result is checked at the falling edge that follows. In that same cycle the bench drops the strobe, so the cycle after shows an idle, zeroed result. Expected results come from a bench model of the nine registers that is updated alongside each write, so every lookup is judged against the configuration in force when it was captured.

// File: rtl/owt_pkg.sv
package owt_pkg;

  typedef enum logic [1:0] {
    RK_RANGE = 2'd0,
    RK_BASE  = 2'd1,
    RK_REMAP = 2'd2,
    RK_NONE  = 2'd3
  } reg_kind_e;

  localparam int unsigned WIN_REG_BASE = 32'h120;
  localparam int unsigned WIN_STRIDE   = 12;
  localparam int unsigned REGS_PER_WIN = 3;
  localparam int unsigned REMAP_EN_BIT = 0;
  localparam int unsigned REMAP_CB_BIT = 2;

endpackage

// File: rtl/owt_reset_sync.sv
module owt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/owt_win_regs.sv
module owt_win_regs
  import owt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GRAN_LSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  reg_kind_e         wr_kind,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] mask_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              en_o,
  output logic              cb_o,
  output logic [ADDR_W-1:0] remap_rb_o
);

  localparam int unsigned HI_W = ADDR_W - GRAN_LSB;

  logic [ADDR_W-1:0] mask_q, mask_d;
  logic [HI_W-1:0]   base_q, base_d;
  logic [HI_W-1:0]   tgt_q,  tgt_d;
  logic              en_q,   en_d;
  logic              cb_q,   cb_d;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[GRAN_LSB-1:REMAP_CB_BIT+1], wr_data[REMAP_EN_BIT+1]};

  always_comb begin
    mask_d = mask_q;
    base_d = base_q;
    tgt_d  = tgt_q;
    en_d   = en_q;
    cb_d   = cb_q;
    unique case (wr_kind)
      RK_RANGE: mask_d = wr_data;
      RK_BASE:  base_d = wr_data[ADDR_W-1:GRAN_LSB];
      RK_REMAP: begin
        tgt_d = wr_data[ADDR_W-1:GRAN_LSB];
        en_d  = wr_data[REMAP_EN_BIT];
        cb_d  = wr_data[REMAP_CB_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      tgt_q  <= '0;
      en_q   <= 1'b0;
      cb_q   <= 1'b0;
    end else if (wr_sel) begin
      mask_q <= mask_d;
      base_q <= base_d;
      tgt_q  <= tgt_d;
      en_q   <= en_d;
      cb_q   <= cb_d;
    end
  end

  always_comb begin
    remap_rb_o                 = {tgt_q, {GRAN_LSB{1'b0}}};
    remap_rb_o[REMAP_EN_BIT]   = en_q;
    remap_rb_o[REMAP_CB_BIT]   = cb_q;
  end

  assign mask_o = mask_q;
  assign base_o = {base_q, {GRAN_LSB{1'b0}}};
  assign tgt_o  = {tgt_q,  {GRAN_LSB{1'b0}}};
  assign en_o   = en_q;
  assign cb_o   = cb_q;

endmodule

// File: rtl/owt_win_match.sv
module owt_win_match #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] tgt,
  input  logic              en,
  output logic              hit,
  output logic [ADDR_W-1:0] xlat
);

  logic [ADDR_W-1:0] addr_hi;
  logic [ADDR_W-1:0] base_hi;

  always_comb begin
    addr_hi = addr & mask;
    base_hi = base & mask;
    hit     = en && (addr_hi == base_hi);
    xlat    = (tgt & mask) | (addr & ~mask);
  end

endmodule

// File: rtl/owt_prio_pick.sv
module owt_prio_pick #(
  parameter int unsigned NUM_WIN = 3,
  parameter int unsigned IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [NUM_WIN-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (req[w]) begin
        idx = IDX_W'(w);
      end
    end
  end

endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
  import owt_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 3,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CFG_AW   = 12,
  parameter int unsigned GRAN_LSB = 15,
  parameter int unsigned IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [CFG_AW-1:0] cfg_rd_addr,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_win,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_cb
);

  logic rst_q_n;

  owt_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // ---------------- register write decode ----------------
  logic [NUM_WIN-1:0] wr_sel;
  reg_kind_e          wr_kind;

  always_comb begin
    wr_sel  = '0;
    wr_kind = RK_NONE;
    for (int w = 0; w < NUM_WIN; w++) begin
      for (int k = 0; k < REGS_PER_WIN; k++) begin
        if (cfg_wr_en &&
            cfg_addr == CFG_AW'(WIN_REG_BASE + w * WIN_STRIDE + k * 4)) begin
          wr_sel[w] = 1'b1;
          wr_kind   = reg_kind_e'(2'(k));
        end
      end
    end
  end

  // ---------------- per-window registers and comparators ----------------
  logic [ADDR_W-1:0]  win_mask  [NUM_WIN];
  logic [ADDR_W-1:0]  win_base  [NUM_WIN];
  logic [ADDR_W-1:0]  win_tgt   [NUM_WIN];
  logic [ADDR_W-1:0]  win_remap [NUM_WIN];
  logic [ADDR_W-1:0]  win_xlat  [NUM_WIN];
  logic [NUM_WIN-1:0] win_en;
  logic [NUM_WIN-1:0] win_cb;
  logic [NUM_WIN-1:0] match_vec;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    owt_win_regs #(
      .ADDR_W   (ADDR_W),
      .GRAN_LSB (GRAN_LSB)
    ) u_regs (
      .clk        (clk),
      .rst_n      (rst_q_n),
      .wr_sel     (wr_sel[g]),
      .wr_kind    (wr_kind),
      .wr_data    (cfg_wdata),
      .mask_o     (win_mask[g]),
      .base_o     (win_base[g]),
      .tgt_o      (win_tgt[g]),
      .en_o       (win_en[g]),
      .cb_o       (win_cb[g]),
      .remap_rb_o (win_remap[g])
    );

    owt_win_match #(
      .ADDR_W (ADDR_W)
    ) u_match (
      .addr (lk_addr),
      .mask (win_mask[g]),
      .base (win_base[g]),
      .tgt  (win_tgt[g]),
      .en   (win_en[g]),
      .hit  (match_vec[g]),
      .xlat (win_xlat[g])
    );
  end

  // ---------------- register readback ----------------
  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (cfg_rd_addr == CFG_AW'(WIN_REG_BASE + w * WIN_STRIDE))
        cfg_rdata = win_mask[w];
      if (cfg_rd_addr == CFG_AW'(WIN_REG_BASE + w * WIN_STRIDE + 4))
        cfg_rdata = win_base[w];
      if (cfg_rd_addr == CFG_AW'(WIN_REG_BASE + w * WIN_STRIDE + 8))
        cfg_rdata = win_remap[w];
    end
  end

  // ---------------- priority selection ----------------
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;

  owt_prio_pick #(
    .NUM_WIN (NUM_WIN),
    .IDX_W   (IDX_W)
  ) u_pick (
    .req (match_vec),
    .any (pick_any),
    .idx (pick_idx)
  );

  logic [ADDR_W-1:0] sel_xlat;
  logic              sel_cb;

  always_comb begin
    sel_xlat = '0;
    sel_cb   = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (pick_idx == IDX_W'(w)) begin
        sel_xlat = win_xlat[w];
        sel_cb   = win_cb[w];
      end
    end
  end

  // ---------------- result stage ----------------
  logic              valid_d, hit_d, cb_d, res_ce;
  logic [IDX_W-1:0]  win_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    valid_d = lk_valid;
    hit_d   = 1'b0;
    win_d   = '0;
    addr_d  = '0;
    cb_d    = 1'b0;
    if (lk_valid && pick_any) begin
      hit_d  = 1'b1;
      win_d  = pick_idx;
      addr_d = sel_xlat;
      cb_d   = sel_cb;
    end
    res_ce = lk_valid | res_valid;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_win   <= '0;
      res_addr  <= '0;
      res_cb    <= 1'b0;
    end else if (res_ce) begin
      res_valid <= valid_d;
      res_hit   <= hit_d;
      res_win   <= win_d;
      res_addr  <= addr_d;
      res_cb    <= cb_d;
    end
  end

endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk
  import owt_pkg::*;
#(
  parameter int unsigned NUM_WIN  = 3,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned CFG_AW   = 12,
  parameter int unsigned GRAN_LSB = 15,
  parameter int unsigned IDX_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              res_valid,
  input logic              res_hit,
  input logic [IDX_W-1:0]  res_win,
  input logic [ADDR_W-1:0] res_addr,
  input logic              res_cb,
  input logic [NUM_WIN-1:0] win_en,
  input logic [NUM_WIN-1:0] win_cb,
  input logic [NUM_WIN-1:0] match_vec,
  input logic [CFG_AW-1:0] cfg_rd_addr,
  input logic [ADDR_W-1:0] cfg_rdata
);

  logic               lk_seen;
  logic [NUM_WIN-1:0] en_seen, cb_seen, match_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_seen    <= 1'b0;
      en_seen    <= '0;
      cb_seen    <= '0;
      match_seen <= '0;
    end else begin
      lk_seen    <= lk_valid;
      en_seen    <= win_en;
      cb_seen    <= win_cb;
      match_seen <= match_vec;
    end
  end

  logic en_at, cb_at, match_at, lower_hit, rd_is_base;

  always_comb begin
    en_at     = 1'b0;
    cb_at     = 1'b0;
    match_at  = 1'b0;
    lower_hit = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (res_win == IDX_W'(w)) begin
        en_at    = en_seen[w];
        cb_at    = cb_seen[w];
        match_at = match_seen[w];
      end
      if (IDX_W'(w) < res_win && match_seen[w]) lower_hit = 1'b1;
    end
    rd_is_base = 1'b0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (cfg_rd_addr == CFG_AW'(WIN_REG_BASE + w * WIN_STRIDE + 4)) rd_is_base = 1'b1;
    end
  end

  assert_valid_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == lk_seen);

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_win == '0 && res_addr == '0 && !res_cb));

  assert_hit_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_valid && en_at && match_at));

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> !lower_hit);

  assert_cb_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_cb == cb_at));

  assert_base_gran_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_base |-> (cfg_rdata[GRAN_LSB-1:0] == '0));

endmodule

bind owt_xlate owt_xlate_chk #(
  .NUM_WIN  (NUM_WIN),
  .ADDR_W   (ADDR_W),
  .CFG_AW   (CFG_AW),
  .GRAN_LSB (GRAN_LSB),
  .IDX_W    (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .lk_valid    (lk_valid),
  .res_valid   (res_valid),
  .res_hit     (res_hit),
  .res_win     (res_win),
  .res_addr    (res_addr),
  .res_cb      (res_cb),
  .win_en      (win_en),
  .win_cb      (win_cb),
  .match_vec   (match_vec),
  .cfg_rd_addr (cfg_rd_addr),
  .cfg_rdata   (cfg_rdata)
);

// File: tb/tb_owt_xlate.sv
`timescale 1ns/1ps
module tb_owt_xlate;

  localparam int NW = 3;
  localparam int AW = 32;
  localparam int CW = 12;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [CW-1:0] cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic [CW-1:0] cfg_rd_addr;
  logic [AW-1:0] cfg_rdata;
  logic          lk_valid;
  logic [AW-1:0] lk_addr;
  logic          res_valid, res_hit, res_cb;
  logic [IW-1:0] res_win;
  logic [AW-1:0] res_addr;

  owt_xlate dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_win(res_win),
    .res_addr(res_addr), .res_cb(res_cb)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_mask [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_tgt  [NW];
  logic        m_en   [NW];
  logic        m_cb   [NW];

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [11:0] off(int w, int k);
    return 12'(32'h120 + w * 12 + k * 4);
  endfunction

  function automatic logic [31:0] rb_exp(logic [11:0] a);
    logic [31:0] r = '0;
    for (int w = 0; w < NW; w++) begin
      if (a == off(w, 0)) r = m_mask[w];
      if (a == off(w, 1)) r = m_base[w];
      if (a == off(w, 2)) r = m_tgt[w] | {29'd0, m_cb[w], 1'b0, m_en[w]};
    end
    return r;
  endfunction

  // {hit, win[1:0], addr[31:0], cb}
  function automatic logic [35:0] exp_lk(logic [31:0] a);
    for (int w = 0; w < NW; w++) begin
      if (m_en[w] && ((a & m_mask[w]) == (m_base[w] & m_mask[w])))
        return {1'b1, 2'(w), (m_tgt[w] & m_mask[w]) | (a & ~m_mask[w]), m_cb[w]};
    end
    return '0;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    for (int w = 0; w < NW; w++) begin
      if (a == off(w, 0)) m_mask[w] = d;
      if (a == off(w, 1)) m_base[w] = d & 32'hFFFF_8000;
      if (a == off(w, 2)) begin
        m_tgt[w] = d & 32'hFFFF_8000; m_en[w] = d[0]; m_cb[w] = d[2];
      end
    end
  endtask

  task automatic rd_chk(string req, logic [11:0] a);
    cfg_rd_addr = a;
    #1;
    chk(req, 64'(cfg_rdata), 64'(rb_exp(a)));
  endtask

  task automatic lk(string req, logic [31:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    chk(req, 64'({res_valid, res_hit, res_win, res_addr, res_cb}), 64'({1'b1, exp_lk(a)}));
    lk_valid = 1'b0;
  endtask

  task automatic rd_all(string req);
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 3; k++) rd_chk(req, off(w, k));
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int w = 0; w < NW; w++) begin
      m_mask[w] = '0; m_base[w] = '0; m_tgt[w] = '0; m_en[w] = 1'b0; m_cb[w] = 1'b0;
    end
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cfg_rd_addr = '0; lk_valid = 1'b0; lk_addr = '0;
    void'($urandom(32'h5EED_0A17));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd_all("R1 reset readback");
    lk("R1 reset miss", 32'h0000_0000);
    lk("R1 reset miss", 32'hDEAD_BEEF);

    // R10: idle cycle after a lookup
    @(negedge clk);
    chk("R10 idle result", 64'({res_valid, res_hit, res_win, res_addr, res_cb}), 64'd0);

    // R2 / R3 masking
    wr(off(0, 1), 32'hFFFF_FFFF);
    rd_chk("R2 base low bits zero", off(0, 1));
    wr(off(1, 2), 32'hFFFF_FFFF);
    rd_chk("R3 remap fields", off(1, 2));
    wr(off(2, 0), 32'hA5A5_5A5B);
    rd_chk("R3 mask full width", off(2, 0));

    // R4: distinct values at every offset
    for (int w = 0; w < NW; w++)
      for (int k = 0; k < 3; k++) wr(off(w, k), 32'h1357_9BDF ^ (32'h1111_0000 * (w * 3 + k + 1)));
    rd_all("R4 offset map");

    // R11: unmapped and misaligned offsets
    wr(12'h121, 32'hFFFF_FFFF);
    wr(12'h11C, 32'hFFFF_FFFF);
    wr(12'h144, 32'hFFFF_FFFF);
    wr(12'h12A, 32'hFFFF_FFFF);
    rd_all("R11 ignored writes");
    rd_chk("R11 unmapped read", 12'h144);
    rd_chk("R11 misaligned read", 12'h125);

    // R5 / R8: window 0 at 0x1000_0000, 1 MiB, target 0x2000_0000
    for (int w = 0; w < NW; w++) wr(off(w, 2), 32'h0);
    wr(off(0, 0), 32'hFFF0_0000);
    wr(off(0, 1), 32'h1000_0000);
    wr(off(0, 2), 32'h2000_0001);
    lk("R5 inside top", 32'h100F_FFFF);
    lk("R5 above", 32'h1010_0000);
    lk("R5 below", 32'h0FFF_FFFF);
    lk("R8 translated", 32'h1001_2345);

    // R6: disable
    wr(off(0, 2), 32'h2000_0000);
    lk("R6 disabled miss", 32'h1001_2345);

    // R7: overlap windows 0 and 1
    wr(off(0, 2), 32'h2000_0001);
    wr(off(1, 0), 32'hF000_0000);
    wr(off(1, 1), 32'h1000_0000);
    wr(off(1, 2), 32'h4000_0005);
    lk("R7 lowest wins", 32'h1000_8000);
    wr(off(0, 2), 32'h0);
    lk("R7 next window", 32'h1000_8000);

    // R9: I/O window switched between PCI and CardBus
    wr(off(1, 2), 32'h0);
    wr(off(2, 0), 32'hFFFF_0000);
    wr(off(2, 1), 32'h0800_0000);
    wr(off(2, 2), 32'h0800_0005);
    lk("R9 io to cardbus", 32'h0800_1234);
    wr(off(2, 2), 32'h0800_0001);
    lk("R9 io to pci", 32'h0800_1234);

    // Random configurations
    for (int round = 0; round < 20; round++) begin
      for (int w = 0; w < NW; w++) begin
        logic [31:0] mk;
        if ($urandom_range(3, 0) != 0) mk = ~((32'h1 << $urandom_range(30, 15)) - 1);
        else mk = $urandom;
        wr(off(w, 0), mk);
        wr(off(w, 1), $urandom);
        wr(off(w, 2), $urandom);
      end
      rd_all("R4 random readback");
      for (int n = 0; n < 10; n++) begin
        int w = int'($urandom_range(NW - 1, 0));
        logic [31:0] a;
        if ($urandom_range(3, 0) != 0) a = (m_base[w] & m_mask[w]) | ($urandom & ~m_mask[w]);
        else a = $urandom;
        lk("R5 R7 R8 R9 random lookup", a);
      end
    end

    @(negedge clk);
    chk("R10 final idle", 64'({res_valid, res_hit, res_win, res_addr, res_cb}), 64'd0);
    summary();
  end

endmodule